// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block keeps a small set of recently used page-table entries so that most address translations finish without a trip to memory. A lookup presents a virtual page number. In the same cycle the block answers with a hit flag, the physical frame number, the access-rights bits, and the entry's current dirty and referenced flags. The match compares the page number against every stored tag at once. A miss tells the surrounding logic to run a full page-table walk.

When the walk finishes, the result is installed through a separate fill port. The fill picks its slot in this order: the lowest-numbered empty slot, and if there is none, the slot named by a rotating replacement pointer. Any hit marks its entry as referenced. A hit for a store also marks the entry dirty. A single-cycle flush input empties the whole buffer. Writing the dirty and referenced flags back to the page table, and the walker itself, belong to other blocks.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is empty, so every lookup misses.
- R2: When `lk_valid` is high and a stored entry holds a tag equal to `lk_vpn`, the block drives `lk_hit` high in that same cycle. In that cycle it also drives that entry's frame, rights, dirty flag and referenced flag.
- R3: On a miss, or when `lk_valid` is low, `lk_hit`, `lk_pfn`, `lk_rights`, `lk_dirty` and `lk_ref` are all zero.
- R4: Every hit sets the entry's referenced flag. Lookups see the new value from the next cycle on.
- R5: A hit with `lk_store` high sets the entry's dirty flag from the next cycle on. A hit with `lk_store` low leaves the dirty flag as it was.
- R6: A fill writes the lowest-numbered empty slot and installs the entry with its dirty and referenced flags clear.
- R7: When all slots are occupied, a fill overwrites the slot named by the replacement pointer. The pointer is 0 after reset. It advances by one after each such overwrite and wraps from ENTRIES-1 back to 0.
- R8: `flush` empties every entry in one cycle. A fill presented in the same cycle is discarded. The replacement pointer keeps its value across a flush.
- R9: A lookup made in the cycle of a fill sees the contents from before that fill. The installed entry is visible from the next cycle. If a fill and a status update land on the same slot, the fill's content wins.
- R10: At most one stored entry ever matches a lookup. The fill source must never install a page number that is already present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_store | input | 1 | Lookup belongs to a store |
| lk_hit | output | 1 | Translation found |
| lk_pfn | output | PFN_W | Physical frame number of the hit |
| lk_rights | output | RT_W | Access-rights bits of the hit |
| lk_dirty | output | 1 | Dirty flag of the hit entry before this lookup |
| lk_ref | output | 1 | Referenced flag of the hit entry before this lookup |
| fill_valid | input | 1 | Install an entry |
| fill_vpn | input | VPN_W | Page number of the new entry |
| fill_pfn | input | PFN_W | Frame number of the new entry |
| fill_rights | input | RT_W | Access rights of the new entry |
| flush | input | 1 | Empty every entry |

## Verification
The bench builds the block with its default parameters: 16 entries, 20-bit page numbers, 18-bit frames and 3 rights bits. Because there are only 16 slots, a few dozen fills are enough to wrap the replacement pointer several times. They also make it possible to flush while the pointer sits at a non-zero position, so the empty-slot-first rule can be seen alongside the preserved pointer. The random phase draws page numbers from a range of 48 values, about three times the capacity. That keeps hits, misses, evictions and repeated status updates frequent, while the page width stays at its full size.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Status carried alongside each cached translation
  typedef struct packed {
    logic valid;
    logic dirty;
    logic refd;
  } tlb_flags_t;

  localparam int unsigned TLB_ENTRIES_DEF = 16;
  localparam int unsigned TLB_VPN_W_DEF   = 20;
  localparam int unsigned TLB_PFN_W_DEF   = 18;
  localparam int unsigned TLB_RT_W_DEF    = 3;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned N     = 16,
  parameter int unsigned VPN_W = 20,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [VPN_W-1:0] tags [N],
  input  logic [N-1:0]     valid_vec,
  input  logic [VPN_W-1:0] vpn,
  output logic [N-1:0]     match_vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // Parallel tag comparators, one per slot
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] && (tags[g] == vpn);
  end

  assign any = |match_vec;

  // Lowest-index match wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     valid_vec,
  input  logic             advance,
  output logic [IDX_W-1:0] victim,
  output logic             full
);

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;

  assign full = &valid_vec;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign victim = full ? rr_ptr : free_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (advance) begin
      rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = TLB_ENTRIES_DEF,
  parameter int unsigned VPN_W   = TLB_VPN_W_DEF,
  parameter int unsigned PFN_W   = TLB_PFN_W_DEF,
  parameter int unsigned RT_W    = TLB_RT_W_DEF,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_store,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic [RT_W-1:0]  lk_rights,
  output logic             lk_dirty,
  output logic             lk_ref,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [RT_W-1:0]  fill_rights,
  input  logic             flush
);

  logic [VPN_W-1:0] tag_tab [ENTRIES];
  logic [PFN_W-1:0] pfn_tab [ENTRIES];
  logic [RT_W-1:0]  rt_tab  [ENTRIES];
  logic [ENTRIES-1:0] valid_vec, dirty_vec, ref_vec;

  logic [ENTRIES-1:0] match_vec;
  logic               match_any;
  logic [IDX_W-1:0]   match_idx;
  logic [IDX_W-1:0]   victim;
  logic               full;
  logic               do_fill;
  logic               do_hit;
  tlb_flags_t         hit_flags;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W)) u_match (
    .tags      (tag_tab),
    .valid_vec (valid_vec),
    .vpn       (lk_vpn),
    .match_vec (match_vec),
    .any       (match_any),
    .idx       (match_idx)
  );

  assign do_fill = fill_valid && !flush;
  assign do_hit  = lk_valid && match_any;

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk       (clk),
    .rst       (rst),
    .valid_vec (valid_vec),
    .advance   (do_fill && full),
    .victim    (victim),
    .full      (full)
  );

  // Read side: same-cycle answer, zero on miss
  always_comb begin
    hit_flags = '{valid: valid_vec[match_idx],
                  dirty: dirty_vec[match_idx],
                  refd:  ref_vec[match_idx]};
    lk_hit    = do_hit;
    lk_pfn    = do_hit ? pfn_tab[match_idx] : '0;
    lk_rights = do_hit ? rt_tab[match_idx]  : '0;
    lk_dirty  = do_hit && hit_flags.dirty;
    lk_ref    = do_hit && hit_flags.refd;
  end

  // Status flags: hit updates first, fill content overrides
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_vec <= '0;
      dirty_vec <= '0;
      ref_vec   <= '0;
    end else if (flush) begin
      valid_vec <= '0;
    end else begin
      if (do_hit) begin
        ref_vec[match_idx] <= 1'b1;
        if (lk_store) dirty_vec[match_idx] <= 1'b1;
      end
      if (fill_valid) begin
        valid_vec[victim] <= 1'b1;
        dirty_vec[victim] <= 1'b0;
        ref_vec[victim]   <= 1'b0;
      end
    end
  end

  // Payload storage: single write port, no reset
  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_tab[victim] <= fill_vpn;
      pfn_tab[victim] <= fill_pfn;
      rt_tab[victim]  <= fill_rights;
    end
  end

endmodule

// File: rtl/tlb_fa_checker.sv
module tlb_fa_checker #(
  parameter int unsigned N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         lk_valid,
  input logic         lk_store,
  input logic         lk_hit,
  input logic         fill_valid,
  input logic         flush,
  input logic [N-1:0] match_vec,
  input logic [N-1:0] valid_vec,
  input logic [N-1:0] dirty_vec,
  input logic [N-1:0] ref_vec
);

  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (valid_vec == '0));

  p_single_match_r10: assert property (@(posedge clk) disable iff (rst)
    $countones(match_vec) <= 1);

  p_hit_marks_ref_r4: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_hit && !fill_valid && !flush)
      |=> ((ref_vec & $past(match_vec)) == $past(match_vec)));

  p_store_marks_dirty_r5: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_hit && lk_store && !fill_valid && !flush)
      |=> ((dirty_vec & $past(match_vec)) == $past(match_vec)));

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_vec == '0));

  p_fill_occupies_r6: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !flush) |=> (valid_vec != '0));

  p_miss_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> !lk_hit);

endmodule

bind tlb_fa tlb_fa_checker #(.N(ENTRIES)) u_tlb_fa_checker (
  .clk        (clk),
  .rst        (rst),
  .lk_valid   (lk_valid),
  .lk_store   (lk_store),
  .lk_hit     (lk_hit),
  .fill_valid (fill_valid),
  .flush      (flush),
  .match_vec  (match_vec),
  .valid_vec  (valid_vec),
  .dirty_vec  (dirty_vec),
  .ref_vec    (ref_vec)
);

// File: tb/test_tlb_fa.sv
`timescale 1ns/1ps
module test_tlb_fa;

  localparam int N     = 16;
  localparam int VPN_W = 20;
  localparam int PFN_W = 18;
  localparam int RT_W  = 3;

  logic             clk = 1'b0;
  logic             rst;
  logic             lk_valid, lk_store, lk_hit, lk_dirty, lk_ref;
  logic [VPN_W-1:0] lk_vpn;
  logic [PFN_W-1:0] lk_pfn;
  logic [RT_W-1:0]  lk_rights;
  logic             fill_valid, flush;
  logic [VPN_W-1:0] fill_vpn;
  logic [PFN_W-1:0] fill_pfn;
  logic [RT_W-1:0]  fill_rights;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tlb_fa #(.ENTRIES(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .RT_W(RT_W)) i_tlb_fa (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_store(lk_store),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_rights(lk_rights),
    .lk_dirty(lk_dirty), .lk_ref(lk_ref),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_rights(fill_rights), .flush(flush)
  );

  // Reference model
  bit               m_v [N];
  bit               m_d [N];
  bit               m_r [N];
  logic [VPN_W-1:0] m_tag [N];
  logic [PFN_W-1:0] m_pfn [N];
  logic [RT_W-1:0]  m_rt  [N];
  int               m_ptr;

  function automatic int m_find(logic [VPN_W-1:0] v);
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == v) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_d[i] = 0; m_r[i] = 0;
    end
    m_ptr = 0;
  endtask

  task automatic step(string req, bit lv, logic [VPN_W-1:0] vpn, bit st,
                      bit fv, logic [VPN_W-1:0] fvpn, logic [PFN_W-1:0] fpfn,
                      logic [RT_W-1:0] frt, bit fl);
    int k;
    int vic;
    logic [PFN_W+RT_W+2:0] exp_v, act_v;
    @(negedge clk);
    lk_valid = lv; lk_vpn = vpn; lk_store = st;
    fill_valid = fv; fill_vpn = fvpn; fill_pfn = fpfn; fill_rights = frt;
    flush = fl;
    #1;
    k = lv ? m_find(vpn) : -1;
    if (k >= 0) exp_v = {1'b1, m_pfn[k], m_rt[k], m_d[k], m_r[k]};
    else        exp_v = '0;
    act_v = {lk_hit, lk_pfn, lk_rights, lk_dirty, lk_ref};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s vpn=%0h actual={hit,pfn,rt,d,r}=%h expected=%h",
               req, vpn, act_v, exp_v);
    end
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else begin
      if (k >= 0) begin
        m_r[k] = 1;
        if (st) m_d[k] = 1;
      end
      if (fv) begin
        vic = m_victim();
        if (vic < 0) begin
          vic = m_ptr;
          m_ptr = (m_ptr + 1) % N;
        end
        m_v[vic] = 1; m_d[vic] = 0; m_r[vic] = 0;
        m_tag[vic] = fvpn; m_pfn[vic] = fpfn; m_rt[vic] = frt;
      end
    end
  endtask

  task automatic look(string req, logic [VPN_W-1:0] vpn, bit st);
    step(req, 1, vpn, st, 0, '0, '0, '0, 0);
  endtask

  task automatic fill(string req, logic [VPN_W-1:0] vpn, logic [PFN_W-1:0] pfn,
                      logic [RT_W-1:0] rt);
    step(req, 0, '0, 0, 1, vpn, pfn, rt, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1357));
    lk_valid = 0; lk_vpn = '0; lk_store = 0;
    fill_valid = 0; fill_vpn = '0; fill_pfn = '0; fill_rights = '0; flush = 0;
    rst = 1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1: empty after reset
    for (int i = 0; i < 4; i++) look("R1", VPN_W'(100 + i), 0);
    // R3: idle lookup drives zeros
    step("R3", 0, VPN_W'(100), 0, 0, '0, '0, '0, 0);

    // R6 / R9: fill slots in order; same-cycle lookup misses
    for (int i = 0; i < N; i++)
      step("R9", 1, VPN_W'(100 + i), 0, 1, VPN_W'(100 + i),
           PFN_W'(20'h3A00 + i * 7), RT_W'(i), 0);
    // R2 / R6: every entry found, flags clear on first hit
    for (int i = 0; i < N; i++) look("R2", VPN_W'(100 + i), 0);
    // R4: referenced now set
    look("R4", VPN_W'(103), 0);
    // R5: load hit keeps dirty clear, store hit sets it
    look("R5", VPN_W'(104), 0);
    look("R5", VPN_W'(104), 1);
    look("R5", VPN_W'(104), 0);
    // R3: absent page misses with zero outputs
    look("R3", VPN_W'(999), 1);

    // R7: full buffer evicts slot 0, then slot 1
    fill("R7", VPN_W'(200), PFN_W'(18'h1111), RT_W'(5));
    look("R7", VPN_W'(100), 0);
    look("R7", VPN_W'(200), 0);
    fill("R7", VPN_W'(201), PFN_W'(18'h2222), RT_W'(6));
    look("R7", VPN_W'(101), 0);
    look("R7", VPN_W'(201), 0);

    // R8: flush beats a concurrent fill
    step("R8", 1, VPN_W'(102), 0, 1, VPN_W'(300), PFN_W'(18'h0ABC), RT_W'(1), 1);
    look("R8", VPN_W'(102), 0);
    look("R8", VPN_W'(300), 0);
    // R8 / R6: refill after flush uses empty slots, pointer stays at 2
    for (int i = 0; i < N; i++) fill("R6", VPN_W'(400 + i), PFN_W'(500 + i), RT_W'(i + 2));
    fill("R8", VPN_W'(450), PFN_W'(18'h0777), RT_W'(7));
    look("R8", VPN_W'(402), 0);
    look("R8", VPN_W'(401), 0);
    look("R8", VPN_W'(450), 0);

    // Random mix against the model
    for (int n = 0; n < 3000; n++) begin
      logic [VPN_W-1:0] lv_vpn, f_vpn;
      bit lv, st, fv, fl;
      lv_vpn = VPN_W'($urandom % 48);
      f_vpn  = VPN_W'($urandom % 48);
      lv = ($urandom % 4) != 0;
      st = $urandom % 2;
      fv = (($urandom % 3) == 0) && (m_find(f_vpn) < 0);
      fl = ($urandom % 200) == 0;
      step("R2", lv, lv_vpn, st, fv, f_vpn, PFN_W'($urandom), RT_W'($urandom), fl);
    end

    finish_run();
  end

endmodule